// File: doc/BRIEF.md
# Receive Timestamp Phase Linearizer

This block merges a coarse receive timestamp with a fine phase measurement into one timestamp with sub-nanosecond resolution that has no steps or gaps as the phase moves. The coarse part comes from two counters that run half a clock cycle apart. One counts on the rising clock edge and the other on the falling edge. Only the rising-edge value is supplied, together with a flag that says whether the rising-edge counter is one tick ahead of the falling-edge counter. The fine part is a phase in picoseconds from a phase detector. A configurable transition point gives the phase at which the rising-edge counter changes.

Near the rising counter's transition, that counter's sampled value cannot be trusted. Within a window of a quarter period on each side of the transition point, the block uses the falling-edge value instead and moves the phase by half a period to match it. Anywhere else it keeps the rising-edge value. The nanosecond result is then folded back into one second, carrying into or borrowing from the seconds field. A result appears a fixed two cycles after each valid input. The raw phase travels alongside the result unchanged.

Top module: `rx_ts_linearizer`

## Requirements
- R1: `out_raw_phase` equals the `in_raw_phase` of the same input beat, unchanged.
- R2: Let the aligned phase A = raw − transition point, plus PERIOD_PS if that is negative. When P/4 ≤ A ≤ 3P/4 (P = PERIOD_PS), the block outputs `in_nsec` and A as `out_phase`.
- R3: When A > 3P/4, the falling-edge value is used: `out_nsec` = `in_nsec` − P/1000 if `in_ahead` = 1, otherwise `in_nsec`. `out_phase` = A.
- R4: When A < P/4, the falling-edge value is used with a carry of one cycle: `out_nsec` = `in_nsec` − (`in_ahead` ? P/1000 : 0) + P/1000. `out_phase` = A.
- R5: A equal to exactly P/4 or exactly 3P/4 selects the rising-edge value. A = P/4 − 1 selects the falling-edge value.
- R6: A nanosecond result of 1,000,000,000 or more has 1,000,000,000 subtracted from it, and `out_sec` = `in_sec` + 1. A result of 999,999,999 passes through unchanged.
- R7: A negative nanosecond result has 1,000,000,000 added to it, and `out_sec` = `in_sec` − 1.
- R8: `out_valid` is high exactly two clock cycles after `in_valid`. A synchronous active-high `rst` clears the pipeline valid flags.
- R9: With counters that agree with the phase (ahead set for A < P/2), a sweep of the raw phase across one period gives `out_nsec`·1000 + `out_phase` that rises by exactly the phase step at every point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_sec | input | SEC_W | Seconds of the rising-edge timestamp |
| in_nsec | input | NSEC_W | Nanoseconds of the rising-edge timestamp |
| in_ahead | input | 1 | Rising-edge counter is one tick ahead of the falling-edge counter |
| in_raw_phase | input | PHASE_W | Measured phase in ps, signed |
| in_trans_point | input | PHASE_W | Phase in ps at which the rising counter changes, in [0, PERIOD_PS) |
| out_valid | output | 1 | Output beat valid |
| out_sec | output | SEC_W | Linearized seconds |
| out_nsec | output | NSEC_W | Linearized nanoseconds, below 1,000,000,000 |
| out_phase | output | PHASE_W | Aligned phase in ps, in [0, PERIOD_PS), signed |
| out_raw_phase | output | PHASE_W | Raw phase passed through, signed |

## Verification
The bench targets the edges of the stability window: an aligned phase exactly at a quarter and at three quarters of the period, and one picosecond inside the window. A comparator that is off by one there would pick the wrong counter and shift the timestamp by a whole clock period. The bench also covers the wrap of the aligned phase when the raw phase lies below the transition point. It drives nanosecond values just below a second boundary and at zero with the ahead flag set, where a missing carry or borrow would leave an out-of-range nanosecond value or the wrong second. A full sweep of the phase with two transition points checks that the merged value never jumps, which catches a half-period shift applied in the wrong direction or a swapped ahead flag.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

   localparam int unsigned NS_PER_SEC = 1_000_000_000;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

endpackage

// File: rtl/rxts_pipe_reg.sv
module rxts_pipe_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         vin,
   input  logic [W-1:0] din,
   output logic         vout,
   output logic [W-1:0] dout
);

   always_ff @(posedge clk) begin
      if (rst) vout <= 1'b0;
      else     vout <= vin;
   end

   always_ff @(posedge clk) begin
      if (vin) dout <= din;
   end

endmodule

// File: rtl/rxts_phase_align.sv
module rxts_phase_align
   import rxts_pkg::*;
#(
   parameter int PERIOD_PS = 8000,
   parameter int PHASE_W   = 32,
   localparam int IW       = PHASE_W + 2
) (
   input  logic signed [PHASE_W-1:0] raw_phase,
   input  logic        [PHASE_W-1:0] trans_point,
   output logic signed [IW-1:0]      phase_rise,
   output logic signed [IW-1:0]      phase_fall,
   output edge_sel_e                 edge_sel
);

   localparam logic signed [IW-1:0] PER  = IW'(PERIOD_PS);
   localparam logic signed [IW-1:0] HALF = IW'(PERIOD_PS / 2);
   localparam logic signed [IW-1:0] Q1   = IW'(PERIOD_PS / 4);
   localparam logic signed [IW-1:0] Q3   = IW'((3 * PERIOD_PS) / 4);

   logic signed [IW-1:0] raw_ext;
   logic signed [IW-1:0] tp_ext;
   logic signed [IW-1:0] diff;
   logic signed [IW-1:0] diff_half;

   always_comb begin
      raw_ext   = {{2{raw_phase[PHASE_W-1]}}, raw_phase};
      tp_ext    = {2'b00, trans_point};
      diff      = raw_ext - tp_ext;
      diff_half = diff + HALF;

      phase_rise = (diff < 0) ? diff + PER : diff;

      if (diff_half < 0)         phase_fall = diff_half + PER;
      else if (diff_half >= PER) phase_fall = diff_half - PER;
      else                       phase_fall = diff_half;

      edge_sel = ((phase_rise > Q3) || (phase_rise < Q1)) ? EDGE_FALL : EDGE_RISE;
   end

endmodule

// File: rtl/rxts_coarse_pick.sv
module rxts_coarse_pick
   import rxts_pkg::*;
#(
   parameter int PERIOD_PS = 8000,
   parameter int PHASE_W   = 32,
   parameter int NSEC_W    = 30,
   localparam int IW       = PHASE_W + 2,
   localparam int NW       = NSEC_W + 2
) (
   input  logic        [NSEC_W-1:0] nsec_rise,
   input  logic                     ahead,
   input  edge_sel_e                edge_sel,
   input  logic signed [IW-1:0]     phase_rise,
   input  logic signed [IW-1:0]     phase_fall,
   output logic signed [NW-1:0]     nsec_out,
   output logic signed [IW-1:0]     phase_out
);

   localparam logic signed [IW-1:0] PER  = IW'(PERIOD_PS);
   localparam logic signed [IW-1:0] HALF = IW'(PERIOD_PS / 2);
   localparam logic signed [NW-1:0] STEP = NW'(PERIOD_PS / 1000);

   logic signed [NW-1:0] ns_r;
   logic signed [NW-1:0] ns_f;
   logic signed [IW-1:0] ph_f_shift;

   always_comb begin
      ns_r       = {2'b00, nsec_rise};
      ns_f       = ahead ? ns_r - STEP : ns_r;
      ph_f_shift = phase_fall + HALF;

      if (edge_sel == EDGE_FALL) begin
         if (ph_f_shift >= PER) begin
            phase_out = ph_f_shift - PER;
            nsec_out  = ns_f + STEP;
         end else begin
            phase_out = ph_f_shift;
            nsec_out  = ns_f;
         end
      end else begin
         phase_out = phase_rise;
         nsec_out  = ns_r;
      end
   end

endmodule

// File: rtl/rxts_sec_wrap.sv
module rxts_sec_wrap
   import rxts_pkg::*;
#(
   parameter int SEC_W  = 40,
   parameter int NSEC_W = 30,
   localparam int NW    = NSEC_W + 2
) (
   input  logic        [SEC_W-1:0]  sec_in,
   input  logic signed [NW-1:0]     nsec_in,
   output logic        [SEC_W-1:0]  sec_out,
   output logic        [NSEC_W-1:0] nsec_out
);

   localparam logic signed [NW-1:0] ONE_SEC = NW'(NS_PER_SEC);

   logic signed [NW-1:0] ns_fix;

   always_comb begin
      if (nsec_in >= ONE_SEC) begin
         ns_fix  = nsec_in - ONE_SEC;
         sec_out = sec_in + SEC_W'(1);
      end else if (nsec_in < 0) begin
         ns_fix  = nsec_in + ONE_SEC;
         sec_out = sec_in - SEC_W'(1);
      end else begin
         ns_fix  = nsec_in;
         sec_out = sec_in;
      end
      nsec_out = ns_fix[NSEC_W-1:0];
   end

endmodule

// File: rtl/rx_ts_linearizer.sv
module rx_ts_linearizer
   import rxts_pkg::*;
#(
   parameter int PERIOD_PS = 8000,
   parameter int PHASE_W   = 32,
   parameter int NSEC_W    = 30,
   parameter int SEC_W     = 40
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic        [SEC_W-1:0]   in_sec,
   input  logic        [NSEC_W-1:0]  in_nsec,
   input  logic                      in_ahead,
   input  logic signed [PHASE_W-1:0] in_raw_phase,
   input  logic        [PHASE_W-1:0] in_trans_point,
   output logic                      out_valid,
   output logic        [SEC_W-1:0]   out_sec,
   output logic        [NSEC_W-1:0]  out_nsec,
   output logic signed [PHASE_W-1:0] out_phase,
   output logic signed [PHASE_W-1:0] out_raw_phase
);

   localparam int IW  = PHASE_W + 2;
   localparam int NW  = NSEC_W + 2;
   localparam int S1W = SEC_W + NW + 2 * PHASE_W;
   localparam int S2W = SEC_W + NSEC_W + 2 * PHASE_W;

   // elaboration-time parameter checks
   if (PERIOD_PS <= 0 || (PERIOD_PS % 4000) != 0) begin : g_bad_period
      $error("PERIOD_PS must be a positive multiple of 4000");
   end
   if (NSEC_W < 30) begin : g_bad_nsec
      $error("NSEC_W must hold one second of nanoseconds");
   end
   if (PHASE_W < 4 || PHASE_W > 62 || longint'(PERIOD_PS) >= (64'sd1 <<< (PHASE_W - 2))) begin : g_bad_phase
      $error("PHASE_W too narrow for PERIOD_PS");
   end

   // stage 1: alignment and edge choice
   logic signed [IW-1:0] ph_rise, ph_fall, ph_sel;
   logic signed [NW-1:0] ns_sel;
   edge_sel_e            sel;

   rxts_phase_align #(.PERIOD_PS(PERIOD_PS), .PHASE_W(PHASE_W)) u_align (
      .raw_phase  (in_raw_phase),
      .trans_point(in_trans_point),
      .phase_rise (ph_rise),
      .phase_fall (ph_fall),
      .edge_sel   (sel)
   );

   rxts_coarse_pick #(.PERIOD_PS(PERIOD_PS), .PHASE_W(PHASE_W), .NSEC_W(NSEC_W)) u_pick (
      .nsec_rise (in_nsec),
      .ahead     (in_ahead),
      .edge_sel  (sel),
      .phase_rise(ph_rise),
      .phase_fall(ph_fall),
      .nsec_out  (ns_sel),
      .phase_out (ph_sel)
   );

   logic [S1W-1:0] s1_d, s1_q;
   logic           s1_v;

   assign s1_d = {in_sec, ns_sel, ph_sel[PHASE_W-1:0], in_raw_phase};

   rxts_pipe_reg #(.W(S1W)) u_s1 (
      .clk (clk),
      .rst (rst),
      .vin (in_valid),
      .din (s1_d),
      .vout(s1_v),
      .dout(s1_q)
   );

   // stage 2: second boundary fold
   logic        [SEC_W-1:0]   s1_sec, s2_sec;
   logic signed [NW-1:0]      s1_ns;
   logic        [NSEC_W-1:0]  s2_ns;
   logic        [PHASE_W-1:0] s1_ph, s1_raw;

   assign {s1_sec, s1_ns, s1_ph, s1_raw} = s1_q;

   rxts_sec_wrap #(.SEC_W(SEC_W), .NSEC_W(NSEC_W)) u_wrap (
      .sec_in  (s1_sec),
      .nsec_in (s1_ns),
      .sec_out (s2_sec),
      .nsec_out(s2_ns)
   );

   logic [S2W-1:0] s2_q;

   rxts_pipe_reg #(.W(S2W)) u_s2 (
      .clk (clk),
      .rst (rst),
      .vin (s1_v),
      .din ({s2_sec, s2_ns, s1_ph, s1_raw}),
      .vout(out_valid),
      .dout(s2_q)
   );

   assign {out_sec, out_nsec, out_phase, out_raw_phase} = s2_q;

endmodule

// File: rtl/rxts_checker.sv
module rxts_checker #(
   parameter int PERIOD_PS = 8000,
   parameter int PHASE_W   = 32,
   parameter int NSEC_W    = 30,
   parameter int SEC_W     = 40
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      in_valid,
   input logic        [SEC_W-1:0]   in_sec,
   input logic        [NSEC_W-1:0]  in_nsec,
   input logic signed [PHASE_W-1:0] in_raw_phase,
   input logic                      out_valid,
   input logic        [SEC_W-1:0]   out_sec,
   input logic        [NSEC_W-1:0]  out_nsec,
   input logic signed [PHASE_W-1:0] out_phase,
   input logic signed [PHASE_W-1:0] out_raw_phase
);

   localparam logic signed [PHASE_W-1:0] PER  = PHASE_W'(PERIOD_PS);
   localparam logic        [NSEC_W:0]    STEP = (NSEC_W+1)'(PERIOD_PS / 1000);
   localparam logic        [NSEC_W-1:0]  ONE_SEC = NSEC_W'(1_000_000_000);

   logic [1:0] cyc;
   always_ff @(posedge clk) begin
      if (rst)             cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R8

   AST_RAW_PASS: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd2 && out_valid) |-> (out_raw_phase == $past(in_raw_phase, 2))); // R1

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_phase >= 0 && out_phase < PER)); // R2

   AST_NSEC_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_nsec < ONE_SEC)); // R6

   AST_NSEC_NEAR: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd2 && out_valid && out_sec == $past(in_sec, 2)) |->
      (({1'b0, out_nsec} + STEP >= {1'b0, $past(in_nsec, 2)}) &&
       ({1'b0, out_nsec} <= {1'b0, $past(in_nsec, 2)} + STEP))); // R3

   AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd2 && out_valid) |->
      ((out_sec == $past(in_sec, 2)) || (out_sec == $past(in_sec, 2) + SEC_W'(1)) ||
       (out_sec == $past(in_sec, 2) - SEC_W'(1)))); // R7

endmodule

bind rx_ts_linearizer rxts_checker #(
   .PERIOD_PS(PERIOD_PS), .PHASE_W(PHASE_W), .NSEC_W(NSEC_W), .SEC_W(SEC_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .in_valid     (in_valid),
   .in_sec       (in_sec),
   .in_nsec      (in_nsec),
   .in_raw_phase (in_raw_phase),
   .out_valid    (out_valid),
   .out_sec      (out_sec),
   .out_nsec     (out_nsec),
   .out_phase    (out_phase),
   .out_raw_phase(out_raw_phase)
);

// File: tb/sim_rx_ts_linearizer.sv
module sim_rx_ts_linearizer;

   localparam int PERIOD_PS = 8000;
   localparam int PHASE_W   = 32;
   localparam int NSEC_W    = 30;
   localparam int SEC_W     = 40;

   logic                      clk = 1'b0;
   logic                      rst = 1'b1;
   logic                      in_valid = 1'b0;
   logic        [SEC_W-1:0]   in_sec = '0;
   logic        [NSEC_W-1:0]  in_nsec = '0;
   logic                      in_ahead = 1'b0;
   logic signed [PHASE_W-1:0] in_raw_phase = '0;
   logic        [PHASE_W-1:0] in_trans_point = '0;
   logic                      out_valid;
   logic        [SEC_W-1:0]   out_sec;
   logic        [NSEC_W-1:0]  out_nsec;
   logic signed [PHASE_W-1:0] out_phase;
   logic signed [PHASE_W-1:0] out_raw_phase;

   always #2 clk = ~clk;

   rx_ts_linearizer #(.PERIOD_PS(PERIOD_PS), .PHASE_W(PHASE_W), .NSEC_W(NSEC_W), .SEC_W(SEC_W)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sec(in_sec), .in_nsec(in_nsec),
      .in_ahead(in_ahead), .in_raw_phase(in_raw_phase), .in_trans_point(in_trans_point),
      .out_valid(out_valid), .out_sec(out_sec), .out_nsec(out_nsec),
      .out_phase(out_phase), .out_raw_phase(out_raw_phase)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // vectors: sec, nsec, ahead, raw, transition point -> sec, nsec, phase
   localparam int NV = 11;
   localparam longint V_SEC  [NV] = '{5, 5, 5, 5, 5, 5, 5, 5, 5, 5, 5};
   localparam longint V_NS   [NV] = '{100, 100, 100, 100, 100, 100, 100, 999999992, 0, 999999999, 100};
   localparam longint V_AH   [NV] = '{0, 1, 1, 0, 1, 1, 0, 0, 1, 0, 0};
   localparam longint V_RAW  [NV] = '{5000, 500, 2500, 2500, 3000, 7000, 7001, 1500, 7500, 4000, 2999};
   localparam longint V_TP   [NV] = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 0, 0, 1000};
   localparam longint E_SEC  [NV] = '{5, 5, 5, 5, 5, 5, 5, 6, 4, 5, 5};
   localparam longint E_NS   [NV] = '{100, 92, 100, 108, 100, 100, 100, 0, 999999992, 999999999, 108};
   localparam longint E_PH   [NV] = '{4000, 7500, 1500, 1500, 2000, 6000, 6001, 500, 7500, 4000, 1999};
   localparam string  V_REQ  [NV] = '{"R2", "R3", "R4", "R4", "R5", "R5", "R3", "R6", "R7", "R6", "R5"};

   // drive one beat at a falling edge, sample two rising edges later
   task automatic run_beat(input longint s, input longint ns, input longint ah,
                           input longint raw, input longint tp);
      @(negedge clk);
      in_valid       = 1'b1;
      in_sec         = SEC_W'(s);
      in_nsec        = NSEC_W'(ns);
      in_ahead       = ah[0];
      in_raw_phase   = PHASE_W'(raw);
      in_trans_point = PHASE_W'(tp);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      // reset held with valid asserted: output stays invalid (R8)
      in_valid = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8 reset valid", longint'(out_valid), 0);
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      chk("R8 idle valid", longint'(out_valid), 0);

      // latency: valid after exactly two edges (R8)
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 one cycle", longint'(out_valid), 0);
      @(negedge clk);
      chk("R8 two cycles", longint'(out_valid), 1);
      @(negedge clk);
      chk("R8 drop", longint'(out_valid), 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         run_beat(V_SEC[i], V_NS[i], V_AH[i], V_RAW[i], V_TP[i]);
         chk({V_REQ[i], " valid"}, longint'(out_valid), 1);
         chk({V_REQ[i], " sec"}, longint'(out_sec), E_SEC[i]);
         chk({V_REQ[i], " nsec"}, longint'(out_nsec), E_NS[i]);
         chk({V_REQ[i], " phase"}, longint'(out_phase), E_PH[i]);
         chk("R1 raw", longint'(out_raw_phase), V_RAW[i]);
      end

      // negative raw phase passes through as is (R1)
      run_beat(7, 500, 0, -300, 0);
      chk("R1 negative raw", longint'(out_raw_phase), -300);

      // sweep with consistent counters (R9)
      for (int t = 0; t < 2; t++) begin
         longint tp;
         longint prev;
         tp   = (t == 0) ? 2500 : 6000;
         prev = 0;
         for (int k = 0; k < 64; k++) begin
            longint raw, a, nsr, comb, exp_comb;
            raw = k * 125;
            a   = raw - tp;
            if (a < 0) a += PERIOD_PS;
            nsr = 1000 + ((raw >= tp) ? 8 : 0);
            run_beat(3, nsr, (a < PERIOD_PS / 2) ? 1 : 0, raw, tp);
            comb     = longint'(out_nsec) * 1000 + longint'(out_phase);
            exp_comb = 1000 * 1000 + 8000 + raw - tp;
            chk("R9 sweep value", comb, exp_comb);
            if (k > 0) chk("R9 sweep step", comb - prev, 125);
            prev = comb;
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule